// File: doc/BRIEF.md
# Arbitrated SPI Flash Programming Bridge

This block sits between a host processor and its boot SPI flash and lets a management processor take the flash over to reprogram it. The manager sees two byte-wide registers on a simple bus: a control register (ownership request, busy flag, manual chip select) and a data register whose write starts one 8-bit SPI exchange.

Ownership of the flash pins moves between host and manager only when the platform reset input falls. Software writes the request bit and then polls the control register until the read-back shows the new owner. While the host owns the flash, its clock, MOSI and chip select pass straight to the flash and flash MISO goes back to the host. The data register is then inert.

The shift engine is a three-state machine. `SH_IDLE` holds SCLK low. A start moves it to `SH_LOW`, which holds SCLK low for half a period and then samples MISO and enters `SH_HIGH`. `SH_HIGH` holds SCLK high for half a period. It then returns to `SH_LOW` with MOSI advanced by one bit, or to `SH_IDLE` once the eighth bit is done. If ownership leaves the manager, either active state returns to `SH_IDLE` at once.

Top module: `spi_prog_bridge`

## Requirements
- R1: After reset the control register (offset 0xD2) reads 0x01, the data register (offset 0xD3) reads 0x00 and the host owns the flash.
- R2: A write to control bit 7 records an ownership request. The owner changes only after a falling edge of `plat_rst_n`, passed through a two-flop synchronizer. Control bit 7 reads the current owner (1 = manager, 0 = host), so it keeps its old value until that edge.
- R3: Control bit 6 reads 1 from the cycle a transfer starts until SCLK has stopped toggling, and 0 otherwise. SCLK rests low whenever no transfer runs.
- R4: While the host owns the flash, `fl_sclk`, `fl_mosi` and `fl_cs_n` follow `host_sclk`, `host_mosi` and `host_cs_n`, and `host_miso` follows `fl_miso`.
- R5: While the host owns the flash, the following have no effect and are read back as follows:
  - writes to the data register start no SCLK pulse;
  - reads of the data register return 0x00;
  - control bit 0 reads 1, and writes to it are ignored.
- R6: While the manager owns the flash, `fl_cs_n` equals control bit 0 and `host_miso` is held at 1.
- R7: While the manager owns the flash, a data register write with busy at 0 produces exactly 8 SCLK pulses. The byte is shifted out MSB first in SPI mode 0: MOSI changes on the falling edge and MISO is sampled on the rising edge.
- R8: A data register read while the manager owns the flash returns the 8 bits captured from MISO by the most recent completed transfer, first-sampled bit as the MSB.
- R9: A data register write while busy is 1 is dropped: the running transfer's MOSI byte and pulse count are unchanged.
- R10: The SCLK period is `CLK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| plat_rst_n | input | 1 | Asynchronous platform reset; its fall commits the ownership request |
| host_sclk | input | 1 | Host SPI clock |
| host_mosi | input | 1 | Host SPI data out |
| host_cs_n | input | 1 | Host chip select, active low |
| host_miso | output | 1 | SPI data returned to the host |
| fl_sclk | output | 1 | Flash SPI clock |
| fl_mosi | output | 1 | Flash SPI data in |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_miso | input | 1 | Flash SPI data out |

## Verification
Some properties are checked by assertions on every cycle:
- the owner changes only in the cycle after a detected reset fall;
- SCLK rests low while idle;
- MOSI is steady while SCLK is high;
- busy never drops before eight rising SCLK edges;
- a data write made while the host owns the flash never raises busy.

Other behaviour is shown only by the bench scenarios:
- the bit order and the byte values exchanged;
- the captured byte read back;
- the SCLK period;
- the host pass-through;
- dropped writes;
- the delayed read-back of the ownership bit.

The bench shows these with a behavioural SPI target over a sweep of byte pairs.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_t;

    localparam logic [7:0] CTRL_OFS = 8'hD2;
    localparam logic [7:0] DATA_OFS = 8'hD3;
    localparam int         OWN_BIT  = 7;
    localparam int         BUSY_BIT = 6;
    localparam int         CS_BIT   = 0;
endpackage

// File: rtl/spb_own_sync.sv
module spb_own_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic plat_rst_n,
    input  logic req,
    output logic owned,
    output logic fall
);
    logic s1, s2, s3;

    // Two-flop synchronizer followed by an edge-history flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= plat_rst_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    owned <= 1'b0;
        else if (fall) owned <= req;
    end
endmodule

// File: rtl/spb_shifter.sv
module spb_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    import spb_pkg::*;

    localparam int HALF  = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    sh_state_t        st, st_n;
    logic [CNT_W-1:0] ph_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;
    logic             ph_end;
    logic             last;

    assign ph_end = (ph_cnt == CNT_W'(HALF - 1));
    assign last   = (bit_cnt == 3'd7);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_n;
    end

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            SH_IDLE: if (start) st_n = SH_LOW;
            SH_LOW:  begin
                if (abort)       st_n = SH_IDLE;
                else if (ph_end) st_n = SH_HIGH;
            end
            SH_HIGH: begin
                if (abort)       st_n = SH_IDLE;
                else if (ph_end) st_n = last ? SH_IDLE : SH_LOW;
            end
            default: st_n = SH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sclk = 1'b0;
        busy = 1'b1;
        unique case (st)
            SH_IDLE: busy = 1'b0;
            SH_LOW:  sclk = 1'b0;
            SH_HIGH: sclk = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign mosi    = tx_sr[7];
    assign done    = (st == SH_HIGH) && ph_end && last && !abort;
    assign rx_byte = rx_sr;

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt  <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else begin
            if (st == SH_IDLE || ph_end) ph_cnt <= '0;
            else                         ph_cnt <= ph_cnt + 1'b1;

            if (st == SH_IDLE && start) begin
                bit_cnt <= '0;
                tx_sr   <= tx_byte;
            end else if (st == SH_HIGH && ph_end) begin
                tx_sr <= {tx_sr[6:0], 1'b0};
                if (!last) bit_cnt <= bit_cnt + 1'b1;
            end

            if (st == SH_LOW && ph_end && !abort)
                rx_sr <= {rx_sr[6:0], miso};
        end
    end
endmodule

// File: rtl/spb_pin_mux.sv
module spb_pin_mux (
    input  logic owned,
    input  logic host_sclk,
    input  logic host_mosi,
    input  logic host_cs_n,
    input  logic sh_sclk,
    input  logic sh_mosi,
    input  logic cs_bit,
    input  logic fl_miso,
    output logic fl_sclk,
    output logic fl_mosi,
    output logic fl_cs_n,
    output logic host_miso
);
    always_comb begin
        if (owned) begin
            fl_sclk   = sh_sclk;
            fl_mosi   = sh_mosi;
            fl_cs_n   = cs_bit;
            host_miso = 1'b1;
        end else begin
            fl_sclk   = host_sclk;
            fl_mosi   = host_mosi;
            fl_cs_n   = host_cs_n;
            host_miso = fl_miso;
        end
    end
endmodule

// File: rtl/spi_prog_bridge.sv
module spi_prog_bridge #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       plat_rst_n,
    input  logic       host_sclk,
    input  logic       host_mosi,
    input  logic       host_cs_n,
    output logic       host_miso,
    output logic       fl_sclk,
    output logic       fl_mosi,
    output logic       fl_cs_n,
    input  logic       fl_miso
);
    import spb_pkg::*;

    logic       req_q, cs_q;
    logic [7:0] rx_q;
    logic       owned, fall;
    logic       sh_sclk, sh_mosi, busy, done, start;
    logic [7:0] sh_rx;
    logic       wr_ctrl, wr_data;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFS);
    assign wr_data = bus_wr && (bus_addr == DATA_OFS);
    assign start   = wr_data && owned && !busy;

    spb_own_sync u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .plat_rst_n (plat_rst_n),
        .req        (req_q),
        .owned      (owned),
        .fall       (fall)
    );

    spb_shifter #(.CLK_DIV(CLK_DIV)) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (!owned),
        .tx_byte (bus_wdata),
        .miso    (fl_miso),
        .sclk    (sh_sclk),
        .mosi    (sh_mosi),
        .busy    (busy),
        .done    (done),
        .rx_byte (sh_rx)
    );

    spb_pin_mux u_mux (
        .owned     (owned),
        .host_sclk (host_sclk),
        .host_mosi (host_mosi),
        .host_cs_n (host_cs_n),
        .sh_sclk   (sh_sclk),
        .sh_mosi   (sh_mosi),
        .cs_bit    (cs_q),
        .fl_miso   (fl_miso),
        .fl_sclk   (fl_sclk),
        .fl_mosi   (fl_mosi),
        .fl_cs_n   (fl_cs_n),
        .host_miso (host_miso)
    );

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cs_q  <= 1'b1;
            rx_q  <= 8'h00;
        end else begin
            if (wr_ctrl) req_q <= bus_wdata[OWN_BIT];
            if (!owned)              cs_q <= 1'b1;
            else if (wr_ctrl)        cs_q <= bus_wdata[CS_BIT];
            if (done) rx_q <= sh_rx;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata[OWN_BIT]  = owned;
            bus_rdata[BUSY_BIT] = busy;
            bus_rdata[CS_BIT]   = cs_q;
        end else if (bus_addr == DATA_OFS) begin
            bus_rdata = owned ? rx_q : 8'h00;
        end
    end
endmodule

// File: rtl/spb_checker.sv
module spb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       owned,
    input logic       fall,
    input logic       busy,
    input logic       sh_sclk,
    input logic       sh_mosi,
    input logic       bus_wr,
    input logic [7:0] bus_addr
);
    import spb_pkg::*;

    logic       sclk_d;
    logic [3:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sh_sclk;
            if (!busy)                   rise_cnt <= '0;
            else if (sh_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    assert_own_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (owned != $past(owned)) |-> $past(fall));

    assert_idle_sclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sh_sclk);

    assert_wr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_OFS && !owned) |=> !busy);

    assert_eight_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && owned) |-> (rise_cnt == 4'd8));

    assert_mosi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_sclk && $past(sh_sclk)) |-> $stable(sh_mosi));
endmodule

bind spi_prog_bridge spb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .owned    (owned),
    .fall     (fall),
    .busy     (busy),
    .sh_sclk  (sh_sclk),
    .sh_mosi  (sh_mosi),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr)
);

// File: tb/sim_spi_prog_bridge.sv
`timescale 1ns/1ps
module sim_spi_prog_bridge;
    localparam int CLK_DIV = 4;
    localparam logic [7:0] CTRL = 8'hD2;
    localparam logic [7:0] DATA = 8'hD3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       plat_rst_n = 1'b1;
    logic       host_sclk = 1'b0, host_mosi = 1'b0, host_cs_n = 1'b1;
    logic       host_miso;
    logic       fl_sclk, fl_mosi, fl_cs_n;
    logic       fl_miso;

    int tests = 0;
    int fails = 0;

    // behavioural SPI target
    logic [7:0] slv_byte = 8'h00;
    logic [7:0] got_mosi = 8'h00;
    int         rises = 0;
    int         falls = 0;
    realtime    t_prev = 0, t_per = 0;
    logic       force_miso_en = 1'b0;
    logic       force_miso = 1'b0;

    always #4 clk = ~clk;

    spi_prog_bridge #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .plat_rst_n(plat_rst_n),
        .host_sclk(host_sclk), .host_mosi(host_mosi), .host_cs_n(host_cs_n),
        .host_miso(host_miso), .fl_sclk(fl_sclk), .fl_mosi(fl_mosi),
        .fl_cs_n(fl_cs_n), .fl_miso(fl_miso)
    );

    assign fl_miso = force_miso_en ? force_miso :
                     (falls < 8) ? slv_byte[3'(7 - falls)] : 1'b1;

    always @(posedge fl_sclk) begin
        got_mosi = {got_mosi[6:0], fl_mosi};
        rises    = rises + 1;
        t_per    = $realtime - t_prev;
        t_prev   = $realtime;
    end
    always @(negedge fl_sclk) falls = falls + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic arm(input logic [7:0] s);
        slv_byte = s; got_mosi = 8'h00; rises = 0; falls = 0;
    endtask

    task automatic plat_pulse();
        @(negedge clk); plat_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        plat_rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] r;
        for (int k = 0; k < 200; k++) begin
            rd(CTRL, r);
            if (!r[6]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, r); check("R1 ctrl", r, 8'h01);
        rd(DATA, r); check("R1 data", r, 8'h00);

        // R4 pass-through under a sweep of host pin values
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            host_sclk = v[0]; host_mosi = v[1]; host_cs_n = v[2];
            force_miso_en = 1'b1; force_miso = v[3];
            #1;
            check("R4 pass", {fl_sclk, fl_mosi, fl_cs_n, host_miso}, {v[0], v[1], v[2], v[3]});
        end
        @(negedge clk);
        host_sclk = 1'b0; host_cs_n = 1'b1; force_miso_en = 1'b0;

        // R5 host owns: data write ignored, bit0 write ignored
        arm(8'h3C);
        wr(DATA, 8'hA5);
        repeat (50) @(negedge clk);
        check("R5 no sclk", rises, 0);
        rd(DATA, r); check("R5 data reads 0", r, 8'h00);
        wr(CTRL, 8'h00);
        rd(CTRL, r); check("R5 cs bit reads 1", r[0], 1'b1);

        // R2 request without reset fall leaves ownership
        wr(CTRL, 8'h80);
        repeat (20) @(negedge clk);
        rd(CTRL, r); check("R2 no fall owner", r[7], 1'b0);
        plat_pulse();
        rd(CTRL, r); check("R2 owner after fall", r[7], 1'b1);

        // R6 manual chip select and MISO hold
        check("R6 cs idle", fl_cs_n, 1'b1);
        wr(CTRL, 8'h80);
        #1 check("R6 cs active", fl_cs_n, 1'b0);
        rd(CTRL, r); check("R6 ctrl readback", r, 8'h80);
        check("R6 host miso high", host_miso, 1'b1);

        // R7 R8 R10 sweep of byte pairs
        for (int i = 0; i < 40; i++) begin
            logic [7:0] tx, sv;
            tx = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 29 + 3);
            sv = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : 8'(i * 71) ^ 8'h5A;
            arm(sv);
            wr(DATA, tx);
            rd(CTRL, r); check("R3 busy set", r[6], 1'b1);
            wait_idle();
            check("R7 pulses", rises, 8);
            check("R7 mosi byte", got_mosi, tx);
            check("R3 sclk rests low", fl_sclk, 1'b0);
            check("R10 period", int'(t_per), CLK_DIV * 8);
            rd(DATA, r); check("R8 captured", r, sv);
        end

        // R9 write while busy dropped
        arm(8'h96);
        wr(DATA, 8'hC3);
        wr(DATA, 8'h18);
        wait_idle();
        check("R9 pulses", rises, 8);
        check("R9 mosi byte", got_mosi, 8'hC3);
        rd(DATA, r); check("R9 captured", r, 8'h96);

        // R2 release back to host
        wr(CTRL, 8'h00);
        repeat (10) @(negedge clk);
        rd(CTRL, r); check("R2 still manager", r[7], 1'b1);
        plat_pulse();
        rd(CTRL, r); check("R2 host again", r, 8'h01);
        rd(DATA, r); check("R5 data 0 after release", r, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule